// File: doc/BRIEF.md
# Four-Channel Reloadable Down-Counter Timer

The block provides four independent down-counting timers behind a small word-addressed register port. Each channel has a reload register and a current-value register. One shared control word holds three settings for every channel: a run/enable flag, an auto-reload flag and a tick-source select. Software presets the count by writing the value register. It then sets the channel's enable flag, and the channel counts down by one on every tick. A counter that hits zero with auto-reload set refills from its reload register on the next tick. Without auto-reload, the channel stops at zero and clears its own enable flag.

A channel ticks either on every bus clock or on a slower reference-rate strobe. The strobe is produced inside the block by a divider of `BUS_CLK_HZ / REF_CLK_HZ`, so the whole design runs in one clock domain. Each channel also drives a one-cycle terminal-count pulse when its count reaches zero. Other logic can use that pulse as an event.

Each channel is a two-state machine. `CH_OFF` means the channel is idle and its value holds. `CH_RUN` means the channel is counting. The machine has four named transitions:
- **start** (`CH_OFF`→`CH_RUN`): a control write with the channel's enable bit set.
- **halt** (`CH_RUN`→`CH_OFF`): a control write with the enable bit clear.
- **expire** (`CH_RUN`→`CH_OFF`): a tick arrives with the count at one or zero and auto-reload clear.
- **count** and **wrap** (`CH_RUN` to itself): a decrement, or a refill from the reload register when a tick arrives at zero.

Top module: `quad_downcount_timer`

## Requirements
- R1: After reset every register reads zero, every channel is in `CH_OFF` and every terminal-count pulse is low.
- R2: Word address 0 is the control word. Address 2n+1 is the reload register of channel n and address 2n+2 is its value register, both read/write. Other addresses read zero and ignore writes.
- R3: In the control word, bit 2n is channel n's enable (it reads back 1 while the channel is in `CH_RUN`), bit 2n+1 its auto-reload flag and bit 11+n its reference-tick select. All other bits read zero.
- R4: A running channel with the select bit clear decrements its value by exactly one on every bus clock.
- R5: With the select bit set, a running channel decrements only on cycles where the reference strobe is high. The strobe is high once every `BUS_CLK_HZ/REF_CLK_HZ` cycles, first in cycle DIV-1 after reset is released.
- R6: A running channel with auto-reload set loads its reload value on a tick taken at a count of zero. It keeps running, and all-ones is a valid reload value.
- R7: Without auto-reload, a tick that brings the count to zero (or arrives at zero) moves the channel to `CH_OFF`. The count stays at zero and the enable bit reads 0.
- R8: The terminal-count output of a channel is high for one cycle. That cycle is the one in which its value register first holds zero after a decrement from one.
- R9: A value-register write in the same cycle as a tick wins: the written value is loaded, and that cycle produces no decrement, stop or pulse.
- R10: A channel in `CH_OFF` holds its value. A control write that clears its enable bit halts it after that cycle's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address of the register access |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| tc_pulse | output | N_CH (4) | Per-channel one-cycle terminal-count pulse |

## Verification
The bench builds the block with four 32-bit channels and clock rates of 100 MHz and 25 MHz, so the reference divider is 4. With a divider of 4, a reference-ticked channel visibly skips three of every four cycles within a short window. Small presets and reload values bring expiry, wrap and the terminal-count pulse within a few dozen cycles. A preset of one with an all-ones reload reaches the full-width wrap in two ticks.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;

    localparam int CTRL_SEL_BASE = 11;

endpackage

// File: rtl/qdt_ref_tick.sv
module qdt_ref_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_pulse
);

    generate
        if (DIV <= 1) begin : g_pass
            assign ref_pulse = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end

            assign ref_pulse = (cnt_q == LAST);

            // R5: the strobe never lasts two cycles when dividing
            p_ref_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ref_pulse |=> !ref_pulse);
        end
    endgenerate

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              ctl_auto,
    input  logic              ctl_sel,
    input  logic              rld_wr,
    input  logic              val_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              running,
    output logic              auto_q,
    output logic              sel_q,
    output logic              tc_pulse
);

    ch_state_e         state_q, state_d;
    logic              tick;
    logic              step;
    logic              at_zero;
    logic              at_one;
    logic [DATA_W-1:0] value_d;
    logic              tc_d;

    assign tick    = sel_q ? ref_pulse : 1'b1;
    assign step    = (state_q == CH_RUN) && tick && !val_wr;
    assign at_zero = (value_q == '0);
    assign at_one  = (value_q == DATA_W'(1));

    // next-state: start, halt, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (ctl_wr && ctl_en) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (ctl_wr) begin
                    state_d = ctl_en ? CH_RUN : CH_OFF;
                end else if (step && !auto_q && (at_one || at_zero)) begin
                    state_d = CH_OFF;
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // count datapath: write wins, then count or wrap
    always_comb begin
        value_d = value_q;
        tc_d    = 1'b0;
        if (val_wr) begin
            value_d = wdata;
        end else if (step) begin
            if (at_zero) begin
                if (auto_q) value_d = reload_q;
            end else begin
                value_d = value_q - DATA_W'(1);
                tc_d    = at_one;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q  <= '0;
            reload_q <= '0;
            auto_q   <= 1'b0;
            sel_q    <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            value_q  <= value_d;
            tc_pulse <= tc_d;
            if (rld_wr) reload_q <= wdata;
            if (ctl_wr) begin
                auto_q <= ctl_auto;
                sel_q  <= ctl_sel;
            end
        end
    end

    // outputs
    always_comb begin
        running = (state_q == CH_RUN);
    end

    p_dec_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_zero) |=> (value_q == $past(value_q) - DATA_W'(1)));

    p_ref_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !ref_pulse && !val_wr) |=> $stable(value_q));

    p_wrap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_zero && auto_q) |=> (value_q == $past(reload_q)));

    p_expire_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_one && !auto_q && !ctl_wr) |=> (!running && value_q == '0));

    p_tc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    p_tc_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> at_zero);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr |=> (value_q == $past(wdata) && !tc_pulse));

    p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !val_wr) |=> $stable(value_q));

endmodule

// File: rtl/qdt_bus_decode.sv
module qdt_bus_decode
    import qdt_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [N_CH-1:0][DATA_W-1:0]  ch_value,
    input  logic [N_CH-1:0][DATA_W-1:0]  ch_reload,
    input  logic [N_CH-1:0]              ch_running,
    input  logic [N_CH-1:0]              ch_auto,
    input  logic [N_CH-1:0]              ch_sel,
    output logic                         ctl_wr,
    output logic [N_CH-1:0]              rld_wr,
    output logic [N_CH-1:0]              val_wr,
    output logic [DATA_W-1:0]            bus_rdata
);

    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word = '0;
        for (int n = 0; n < N_CH; n++) begin
            ctrl_word[2*n]               = ch_running[n];
            ctrl_word[2*n+1]             = ch_auto[n];
            ctrl_word[CTRL_SEL_BASE + n] = ch_sel[n];
        end
    end

    always_comb begin
        ctl_wr = bus_wr && (bus_addr == '0);
        for (int n = 0; n < N_CH; n++) begin
            rld_wr[n] = bus_wr && (bus_addr == ADDR_W'(2*n + 1));
            val_wr[n] = bus_wr && (bus_addr == ADDR_W'(2*n + 2));
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = ctrl_word;
        for (int n = 0; n < N_CH; n++) begin
            if (bus_addr == ADDR_W'(2*n + 1)) bus_rdata = ch_reload[n];
            if (bus_addr == ADDR_W'(2*n + 2)) bus_rdata = ch_value[n];
        end
    end

    // R2: a bus write reaches at most one register
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_wr, rld_wr, val_wr}));

endmodule

// File: rtl/quad_downcount_timer.sv
module quad_downcount_timer
    import qdt_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int DATA_W     = 32,
    parameter int BUS_CLK_HZ = 200_000_000,
    parameter int REF_CLK_HZ = 25_000_000,
    localparam int ADDR_W    = $clog2(2*N_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   tc_pulse
);

    localparam int RATIO   = BUS_CLK_HZ / REF_CLK_HZ;
    localparam int REF_DIV = (RATIO < 1) ? 1 : RATIO;

    logic                        ref_pulse;
    logic                        ctl_wr;
    logic [N_CH-1:0]             rld_wr;
    logic [N_CH-1:0]             val_wr;
    logic [N_CH-1:0][DATA_W-1:0] ch_value;
    logic [N_CH-1:0][DATA_W-1:0] ch_reload;
    logic [N_CH-1:0]             ch_running;
    logic [N_CH-1:0]             ch_auto;
    logic [N_CH-1:0]             ch_sel;

    qdt_ref_tick #(.DIV(REF_DIV)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse)
    );

    qdt_bus_decode #(
        .N_CH   (N_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .ch_value   (ch_value),
        .ch_reload  (ch_reload),
        .ch_running (ch_running),
        .ch_auto    (ch_auto),
        .ch_sel     (ch_sel),
        .ctl_wr     (ctl_wr),
        .rld_wr     (rld_wr),
        .val_wr     (val_wr),
        .bus_rdata  (bus_rdata)
    );

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            qdt_channel #(.DATA_W(DATA_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .ref_pulse (ref_pulse),
                .ctl_wr    (ctl_wr),
                .ctl_en    (bus_wdata[2*i]),
                .ctl_auto  (bus_wdata[2*i+1]),
                .ctl_sel   (bus_wdata[CTRL_SEL_BASE + i]),
                .rld_wr    (rld_wr[i]),
                .val_wr    (val_wr[i]),
                .wdata     (bus_wdata),
                .value_q   (ch_value[i]),
                .reload_q  (ch_reload[i]),
                .running   (ch_running[i]),
                .auto_q    (ch_auto[i]),
                .sel_q     (ch_sel[i]),
                .tc_pulse  (tc_pulse[i])
            );
        end
    endgenerate

endmodule

// File: tb/test_quad_downcount_timer.sv
module test_quad_downcount_timer;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 4;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] tc_pulse;

    always #10 clk = ~clk;

    quad_downcount_timer #(
        .N_CH(NCH), .DATA_W(DW),
        .BUS_CLK_HZ(100_000_000), .REF_CLK_HZ(25_000_000)
    ) i_quad_downcount_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_pulse(tc_pulse)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_val [NCH];
    logic [31:0] m_rld [NCH];
    bit          m_en  [NCH];
    bit          m_auto[NCH];
    bit          m_sel [NCH];
    bit          m_tc  [NCH];
    int          m_rc;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        if (a == 0) begin
            for (int n = 0; n < NCH; n++) begin
                r[2*n]    = m_en[n];
                r[2*n+1]  = m_auto[n];
                r[11+n]   = m_sel[n];
            end
        end else if (a <= 2*NCH) begin
            if (a % 2 == 1) r = m_rld[(a-1)/2];
            else            r = m_val[(a-2)/2];
        end
        return r;
    endfunction

    task automatic m_reset();
        m_rc = 0;
        for (int n = 0; n < NCH; n++) begin
            m_val[n] = 0; m_rld[n] = 0; m_en[n] = 0;
            m_auto[n] = 0; m_sel[n] = 0; m_tc[n] = 0;
        end
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit ref_now;
            ref_now = (m_rc == DIV - 1);
            m_rc = (m_rc + 1) % DIV;
            for (int n = 0; n < NCH; n++) begin
                bit tk;
                bit new_en;
                tk = m_sel[n] ? ref_now : 1'b1;
                new_en = m_en[n];
                m_tc[n] = 0;
                if (bus_wr && bus_addr == AW'(2*n+2)) begin
                    m_val[n] = bus_wdata;
                end else if (m_en[n] && tk) begin
                    if (m_val[n] != 0) begin
                        m_val[n] = m_val[n] - 1;
                        if (m_val[n] == 0) begin
                            m_tc[n] = 1;
                            if (!m_auto[n]) new_en = 0;
                        end
                    end else if (m_auto[n]) begin
                        m_val[n] = m_rld[n];
                    end else begin
                        new_en = 0;
                    end
                end
                if (bus_wr && bus_addr == AW'(2*n+1)) m_rld[n] = bus_wdata;
                if (bus_wr && bus_addr == '0) begin
                    new_en    = bus_wdata[2*n];
                    m_auto[n] = bus_wdata[2*n+1];
                    m_sel[n]  = bus_wdata[11+n];
                end
                m_en[n] = new_en;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, bus_rdata, m_read(int'(bus_addr)));
            for (int n = 0; n < NCH; n++)
                chk("R8 tc", {31'd0, tc_pulse[n]}, {31'd0, m_tc[n]});
        end
    end

    task automatic put(int a, bit w, logic [31:0] d);
        bus_addr = AW'(a); bus_wr = w; bus_wdata = d;
        @(posedge clk); #2;
    endtask

    task automatic idle_rd(int a, int n);
        repeat (n) put(a, 0, 0);
    endtask

    task automatic direct(string req, int a, logic [31:0] exp);
        bus_addr = AW'(a); bus_wr = 1'b0;
        #1;
        chk(req, bus_rdata, exp);
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        chk("R1 tc", {28'd0, tc_pulse}, 32'd0);
        direct("R1 ctrl", 0, 32'd0);
        direct("R1 reload0", 1, 32'd0);
        direct("R1 value0", 2, 32'd0);

        // R2 map and readback, out-of-range ignored
        cur_req = "R2";
        for (int n = 0; n < NCH; n++) begin
            put(2*n+1, 1, 32'hA5A5_0000 + n);
            put(2*n+2, 1, 32'h0000_0100 + n);
        end
        direct("R2 reload1", 3, 32'hA5A5_0001);
        direct("R2 value3", 8, 32'h0000_0103);
        put(12, 1, 32'hFFFF_FFFF);
        direct("R2 out-of-range", 12, 32'd0);
        idle_rd(15, 2);

        // R4 bus-rate count, R7 one-shot expiry
        cur_req = "R4";
        put(2, 1, 5);
        put(0, 1, 32'h0000_0001);
        idle_rd(2, 4);
        cur_req = "R7";
        idle_rd(2, 6);
        direct("R7 enable cleared", 0, 32'd0);
        direct("R7 held at zero", 2, 32'd0);

        // R6 full-width wrap on channel 1
        cur_req = "R6";
        put(3, 1, 32'hFFFF_FFFF);
        put(4, 1, 1);
        put(0, 1, 32'h0000_000C);
        put(4, 0, 0);
        put(4, 0, 0);
        direct("R6 all-ones reload", 4, 32'hFFFF_FFFF);

        // R9 write beats the decrement
        cur_req = "R9";
        put(4, 1, 7);
        direct("R9 written value", 4, 32'd7);
        idle_rd(4, 2);

        // R10 halt and hold
        cur_req = "R10";
        put(0, 1, 32'd0);
        direct("R10 all halted", 0, 32'd0);
        idle_rd(4, 5);

        // R5 reference-rate ticking on channel 3
        cur_req = "R5";
        put(8, 1, 20);
        put(0, 1, (32'd1 << 6) | (32'd1 << 14));
        idle_rd(8, 40);
        put(0, 1, 32'd0);

        // R6 short auto-reload period on channel 2, with pulses
        cur_req = "R6";
        put(5, 1, 3);
        put(6, 1, 2);
        put(0, 1, 32'h0000_0030);
        idle_rd(6, 20);

        // R3 control field positions
        cur_req = "R3";
        put(0, 1, 32'hFFFF_FFFF);
        direct("R3 defined bits only", 0, 32'h0000_78FF);
        idle_rd(0, 6);
        put(0, 1, 32'h0000_0700);
        direct("R3 gap bits read zero", 0, 32'd0);
        idle_rd(2, 3);

        finish_run();
    end

endmodule